// File: doc/BRIEF.md
# Message Data Shadow Buffer

This block gives a host processor byte-wide access to the data fields of sixteen message objects. Each object owns an eight-byte field held in a 16 x 64-bit message RAM. The host never reaches that RAM directly. Every access goes through one 64-bit shadow register, so that a multi-byte read sees one consistent snapshot and a multi-byte write reaches the RAM in a single step. The receive side of a larger controller has its own write port into the same RAM.

The host window starts at address 80h. Object n, byte b sits at 80h + 8n + b, and byte b occupies bits 8b+7 down to 8b of the field. A read refreshes the whole shadow from the RAM when it is the first read of an object, or when it targets byte 7. A write always lands in the shadow, and only a write to byte 0 copies the shadow, with the new byte 0 merged in, into the RAM. The host is expected to run each sequence from byte 7 down to byte 0 and not to mix reads and writes within one sequence.

A small state machine remembers the kind of the last accepted access. Its states are ST_NONE (after reset), ST_READ (last access was a read) and ST_WRITE (last access was a write). Every in-window read moves it to ST_READ. Every in-window write moves it to ST_WRITE. Reset returns it to ST_NONE. An access outside the window leaves the state and the last object index unchanged. A read counts as a first read in ST_NONE and in ST_WRITE, and also in ST_READ when the object index differs from the one last read.

Top module: `msg_shadow_buf`

## Requirements
- R1: Host address 80h + 8n + b selects byte b of object n, and that byte is bits 8b+7..8b of the object's 64-bit field.
- R2: A read request inside the window returns its byte on host_rdata with host_rvalid high in the cycle after the request. host_rvalid is low in every other cycle.
- R3: A first read reloads the whole shadow from the RAM and returns the byte from the fresh contents. A first read is any read in ST_NONE or ST_WRITE, or a read in ST_READ to an object index other than the last one read.
- R4: A read of byte 7 always reloads the shadow from the RAM, even when the same object was read just before.
- R5: A read of bytes 0 to 6 of the object read last, in ST_READ, returns the shadow contents without reloading. RAM changes made after the reload are therefore not visible.
- R6: A write to bytes 1 to 7 changes only the shadow. That object's RAM field keeps its previous value.
- R7: A write to byte 0 stores the shadow, with byte 0 replaced by the written value, into the addressed object's RAM field at the next clock edge.
- R8: The receive port writes a full 64-bit field into the RAM. When it targets the same object in the same cycle as a byte-0 commit, the receive data is stored. When the two target different objects, both are stored.
- R9: Requests at addresses below 80h have no effect: no host_rvalid, no shadow change, and no change to the access state.
- R10: After reset the RAM holds all zeros, host_rvalid is low, host_rdata is zero, and the state is ST_NONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Host access request, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after a read request |
| rx_we | input | 1 | Receive-side field write strobe |
| rx_idx | input | 4 | Receive-side object index |
| rx_data | input | 64 | Receive-side 64-bit data field |

## Verification
The hardest case to reach is a byte-0 commit and a receive write that land on the same object in the same cycle. The bench drives both in one cycle and then reads the whole field back through byte 7 to see which one was stored. Proving that a write to bytes 1 to 7 never reached the RAM is also hard, because the shadow masks the RAM. The bench first reads a different object, which forces a reload on the next read, and only then reads the written object. Stale reads for R5 are set up the same way: the bench changes the RAM through the receive port between reads of one object and expects the old bytes until byte 7 is read again.

// File: rtl/msb_pkg.sv
package msb_pkg;

    typedef enum logic [1:0] {
        ST_NONE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } msb_state_e;

endpackage

// File: rtl/msb_decode.sv
module msb_decode #(
    parameter int NUM_OBJ = 16,
    parameter int BYTES   = 8,
    parameter int BASE    = 128,
    parameter int ADDR_W  = 8,
    localparam int IDX_W  = $clog2(NUM_OBJ),
    localparam int BYTE_W = $clog2(BYTES)
) (
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    output logic              acc_rd,
    output logic              acc_wr,
    output logic              in_win,
    output logic [IDX_W-1:0]  idx,
    output logic [BYTE_W-1:0] byt
);
    localparam int SPAN = NUM_OBJ * BYTES;
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);

    logic [ADDR_W-1:0] off;

    always_comb begin
        off    = host_addr - BASE_V;
        in_win = host_req && (int'(host_addr) >= BASE) && (int'(host_addr) < BASE + SPAN);
        idx    = IDX_W'(off >> BYTE_W);
        byt    = BYTE_W'(off);
        acc_rd = in_win && !host_we;
        acc_wr = in_win && host_we;
    end

endmodule

// File: rtl/msb_ctrl.sv
module msb_ctrl
    import msb_pkg::*;
#(
    parameter int NUM_OBJ = 16,
    parameter int BYTES   = 8,
    localparam int IDX_W  = $clog2(NUM_OBJ),
    localparam int BYTE_W = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] byt,
    output logic              reload,
    output logic              commit
);
    localparam logic [BYTE_W-1:0] LAST = BYTE_W'(BYTES - 1);

    msb_state_e       state_q;
    logic [IDX_W-1:0] last_idx_q;
    logic             first_rd;

    // state register and transitions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_NONE;
            last_idx_q <= '0;
        end else if (acc_rd) begin
            state_q    <= ST_READ;
            last_idx_q <= idx;
        end else if (acc_wr) begin
            state_q    <= ST_WRITE;
            last_idx_q <= idx;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_NONE:  first_rd = 1'b1;
            ST_READ:  first_rd = (idx != last_idx_q);
            ST_WRITE: first_rd = 1'b1;
            default:  first_rd = 1'b1;
        endcase
        reload = acc_rd && (first_rd || (byt == LAST));
        commit = acc_wr && (byt == '0);
    end

    AST_SWITCH_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && state_q == ST_READ && idx != last_idx_q) |-> reload) // R3
        else $error("AST_SWITCH_RELOADS");

    AST_WRITE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |=> (state_q == ST_WRITE)) // R3
        else $error("AST_WRITE_STATE");

endmodule

// File: rtl/msb_shadow.sv
module msb_shadow #(
    parameter int BYTES   = 8,
    localparam int BYTE_W = $clog2(BYTES),
    localparam int FLD_W  = 8 * BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic              reload,
    input  logic [BYTE_W-1:0] byt,
    input  logic [7:0]        wdata,
    input  logic [FLD_W-1:0]  ram_rdata,
    output logic [FLD_W-1:0]  commit_data,
    output logic [7:0]        rdata,
    output logic              rvalid
);
    localparam logic [BYTE_W-1:0] LAST = BYTE_W'(BYTES - 1);

    logic [FLD_W-1:0] shadow_q;

    always_comb begin
        commit_data = shadow_q;
        commit_data[8*byt +: 8] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            rdata    <= '0;
            rvalid   <= 1'b0;
        end else begin
            rvalid <= acc_rd;
            if (reload) begin
                shadow_q <= ram_rdata;
                rdata    <= ram_rdata[8*byt +: 8];
            end else if (acc_rd) begin
                rdata    <= shadow_q[8*byt +: 8];
            end else if (acc_wr) begin
                shadow_q <= commit_data;
            end
        end
    end

    AST_BYTE7_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && byt == LAST) |=> (shadow_q == $past(ram_rdata))) // R4
        else $error("AST_BYTE7_RELOAD");

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_rd && !acc_wr) |=> $stable(shadow_q)) // R9
        else $error("AST_IDLE_HOLDS");

    AST_WRITE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |=> !rvalid) // R2
        else $error("AST_WRITE_NO_READ");

endmodule

// File: rtl/msb_ram.sv
module msb_ram #(
    parameter int NUM_OBJ = 16,
    parameter int BYTES   = 8,
    localparam int IDX_W  = $clog2(NUM_OBJ),
    localparam int FLD_W  = 8 * BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  host_idx,
    output logic [FLD_W-1:0]  host_rfield,
    input  logic              cm_we,
    input  logic [FLD_W-1:0]  cm_data,
    input  logic              rx_we,
    input  logic [IDX_W-1:0]  rx_idx,
    input  logic [FLD_W-1:0]  rx_data
);
    logic [FLD_W-1:0] mem [NUM_OBJ];

    assign host_rfield = mem[host_idx];

    for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
        logic rx_hit, cm_hit;
        assign rx_hit = rx_we && (rx_idx == IDX_W'(g));
        assign cm_hit = cm_we && (host_idx == IDX_W'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      mem[g] <= '0;
            else if (rx_hit) mem[g] <= rx_data;
            else if (cm_hit) mem[g] <= cm_data;
        end
    end

    AST_RX_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_we && cm_we && rx_idx == host_idx) |=> (mem[$past(rx_idx)] == $past(rx_data))) // R8
        else $error("AST_RX_WINS");

    AST_COMMIT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_we && !(rx_we && rx_idx == host_idx)) |=> (mem[$past(host_idx)] == $past(cm_data))) // R7
        else $error("AST_COMMIT_LANDS");

endmodule

// File: rtl/msg_shadow_buf.sv
module msg_shadow_buf #(
    parameter int NUM_OBJ = 16,
    parameter int BYTES   = 8,
    parameter int BASE    = 128,
    localparam int IDX_W  = $clog2(NUM_OBJ),
    localparam int BYTE_W = $clog2(BYTES),
    localparam int FLD_W  = 8 * BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_req,
    input  logic             host_we,
    input  logic [7:0]       host_addr,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    output logic             host_rvalid,
    input  logic             rx_we,
    input  logic [IDX_W-1:0] rx_idx,
    input  logic [FLD_W-1:0] rx_data
);
    logic              acc_rd, acc_wr, in_win, reload, commit;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] byt;
    logic [FLD_W-1:0]  ram_rdata, commit_data;

    msb_decode #(.NUM_OBJ(NUM_OBJ), .BYTES(BYTES), .BASE(BASE), .ADDR_W(8)) u_dec (
        .host_req (host_req),
        .host_we  (host_we),
        .host_addr(host_addr),
        .acc_rd   (acc_rd),
        .acc_wr   (acc_wr),
        .in_win   (in_win),
        .idx      (idx),
        .byt      (byt)
    );

    msb_ctrl #(.NUM_OBJ(NUM_OBJ), .BYTES(BYTES)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .acc_rd(acc_rd),
        .acc_wr(acc_wr),
        .idx   (idx),
        .byt   (byt),
        .reload(reload),
        .commit(commit)
    );

    msb_shadow #(.BYTES(BYTES)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_rd     (acc_rd),
        .acc_wr     (acc_wr),
        .reload     (reload),
        .byt        (byt),
        .wdata      (host_wdata),
        .ram_rdata  (ram_rdata),
        .commit_data(commit_data),
        .rdata      (host_rdata),
        .rvalid     (host_rvalid)
    );

    msb_ram #(.NUM_OBJ(NUM_OBJ), .BYTES(BYTES)) u_ram (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_idx   (idx),
        .host_rfield(ram_rdata),
        .cm_we      (commit),
        .cm_data    (commit_data),
        .rx_we      (rx_we),
        .rx_idx     (rx_idx),
        .rx_data    (rx_data)
    );

    AST_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !in_win) |=> !host_rvalid) // R9
        else $error("AST_OUTSIDE_IGNORED");

    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_we && in_win) |=> host_rvalid) // R2
        else $error("AST_READ_VALID");

endmodule

// File: tb/msg_shadow_buf_tb.sv
module msg_shadow_buf_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [7:0]  host_addr = '0, host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_rvalid;
    logic        rx_we = 1'b0;
    logic [3:0]  rx_idx = '0;
    logic [63:0] rx_data = '0;

    int nchk = 0, nfail = 0;

    always #4 clk = ~clk;

    msg_shadow_buf u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .rx_we(rx_we), .rx_idx(rx_idx), .rx_data(rx_data)
    );

    function automatic logic [7:0] pat(int n, int b, int s);
        return 8'(n * 13 + b * 7 + s * 41 + 3);
    endfunction

    function automatic logic [7:0] adr(int n, int b);
        return 8'(128 + 8 * n + b);
    endfunction

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d, output logic v);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_addr = a;
        @(negedge clk);
        host_req = 1'b0;
        d = host_rdata; v = host_rvalid;
    endtask

    task automatic rd_chk(string tag, int n, int b, logic [7:0] exp);
        logic [7:0] d; logic v;
        rd(adr(n, b), d, v);
        chk({tag, " R2 valid"}, 64'(v), 64'd1);
        chk(tag, 64'(d), 64'(exp));
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic rxw(input int n, input logic [63:0] d);
        @(negedge clk);
        rx_we = 1'b1; rx_idx = 4'(n); rx_data = d;
        @(negedge clk);
        rx_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0] d; logic v;
        logic [63:0] rxd, rxe, rxf;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 rvalid", 64'(host_rvalid), 64'd0);
        chk("R10 rdata", 64'(host_rdata), 64'd0);
        rst_n = 1'b1;
        for (int n = 0; n < 16; n++) rd_chk("R10 ram zero", n, 7, 8'h00);

        // R7 R6: write every object high to low, then read back (R1 R3 R4)
        for (int n = 0; n < 16; n++)
            for (int b = 7; b >= 0; b--) wr(adr(n, b), pat(n, b, 1));
        for (int n = 0; n < 16; n++)
            for (int b = 7; b >= 0; b--) rd_chk("R1 R7 readback", n, b, pat(n, b, 1));

        // R6: partial write never reaches the RAM
        for (int b = 7; b >= 1; b--) wr(adr(3, b), pat(3, b, 2));
        rd_chk("R3 switch object", 4, 7, pat(4, 7, 1));
        rd_chk("R6 byte7 old", 3, 7, pat(3, 7, 1));
        rd_chk("R6 byte1 old", 3, 1, pat(3, 1, 1));

        // R5: stale shadow until byte 7 re-read; R4 reload
        rd_chk("R4 load obj5", 5, 7, pat(5, 7, 1));
        rxd = 64'hA1B2C3D4E5F60718;
        rxw(5, rxd);
        for (int b = 6; b >= 0; b--) rd_chk("R5 stale", 5, b, pat(5, b, 1));
        rd_chk("R4 reread byte7", 5, 7, rxd[63:56]);
        rd_chk("R5 after reload", 5, 3, rxd[31:24]);

        // R3: index change reloads
        rd_chk("R3 obj7 first", 7, 3, pat(7, 3, 1));
        rxe = 64'h1122334455667788;
        rxw(7, rxe);
        rd_chk("R3 obj6", 6, 2, pat(6, 2, 1));
        rd_chk("R3 obj7 back", 7, 3, rxe[31:24]);

        // R3: read after write reloads even on same object
        rd_chk("R3 obj8 load", 8, 4, pat(8, 4, 1));
        rxf = 64'h0F1E2D3C4B5A6978;
        rxw(8, rxf);
        wr(8'h05, 8'h99); // outside, ignored
        wr(adr(2, 6), pat(2, 6, 1));
        rd_chk("R3 after write", 8, 4, rxf[39:32]);

        // R8: same object collision, receive wins
        for (int b = 7; b >= 1; b--) wr(adr(9, b), pat(9, b, 2));
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = adr(9, 0); host_wdata = pat(9, 0, 2);
        rx_we = 1'b1; rx_idx = 4'd9; rx_data = rxd;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0; rx_we = 1'b0;
        for (int b = 7; b >= 0; b--) rd_chk("R8 rx wins", 9, b, rxd[8*b +: 8]);

        // R8: different objects, both stored
        for (int b = 7; b >= 1; b--) wr(adr(10, b), pat(10, b, 3));
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = adr(10, 0); host_wdata = pat(10, 0, 3);
        rx_we = 1'b1; rx_idx = 4'd11; rx_data = rxe;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0; rx_we = 1'b0;
        for (int b = 7; b >= 0; b--) rd_chk("R8 commit kept", 10, b, pat(10, b, 3));
        for (int b = 7; b >= 0; b--) rd_chk("R8 rx kept", 11, b, rxe[8*b +: 8]);

        // R9: outside accesses change nothing
        rd_chk("R9 load obj2", 2, 7, pat(2, 7, 1));
        rxw(2, rxf);
        for (int a = 0; a < 128; a += 9) begin
            rd(8'(a), d, v);
            chk("R9 no rvalid", 64'(v), 64'd0);
        end
        wr(8'h10, 8'h55);
        rd_chk("R9 state kept", 2, 4, pat(2, 4, 1));
        rd_chk("R9 reload later", 2, 7, rxf[63:56]);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule